// File: doc/BRIEF.md
# Receive Ring Pointer Manager

This block keeps the bookkeeping for a 32 KB circular receive store that sits between a receive MAC and a host. Two pointers share the ring, each with its own owner. Hardware owns the current pointer. It moves forward only after a frame has ended good, and then by the frame length rounded up to whole 32-bit words. Software owns the boundary pointer. It writes a new value into that pointer once it has read a frame out of the ring. Both pointers count in words, wrap at the ring size, and carry one extra wrap bit. That bit tells a full ring apart from an empty one when the two addresses are equal.

While a frame is arriving, a private write pointer hands the storage array one word address per write. If the frame ends bad, that pointer falls back to the current pointer, so a partial frame never becomes visible. A frame is only started when the free space left is at least one maximum-size frame. Otherwise the whole frame is discarded and a drop counter goes up. Full, empty and the free word count are worked out from the current and boundary pointers alone. Software reaches both pointers through a small register window. A boundary write that would move the boundary past the current pointer is refused.

Top module: `rxr_ptr_mgr`

## Requirements
- R1: After reset, both pointers are zero, the ring reports empty and not full, `free_words` equals the ring size in words, `drop_count` is zero and `rx_busy` is low.
- R2: A host read at offset 0xFC34 returns the current pointer and one at 0xFC38 returns the boundary pointer. The format is the byte address in bits log2(RING_BYTES)-1 down to 0 (bits 1:0 always zero), the wrap bit at bit log2(RING_BYTES), and zeros above. Any other offset reads zero. Host writes to 0xFC34 change nothing.
- R3: A start pulse while idle opens a frame when `free_words` is at least MAX_FRAME_BYTES/4. The words of that frame get consecutive byte addresses `rx_wr_addr`, starting at the current pointer and wrapping at the ring end. `rx_wr_ok` is high for the first MAX_FRAME_BYTES/4 writes only, and low for any write after those.
- R4: A good end whose length is at most MAX_FRAME_BYTES moves the current pointer forward by ceil(length/4) words, modulo twice the ring, on the clock edge of the end pulse.
- R5: A bad end, or a good end with a length above MAX_FRAME_BYTES, leaves the current pointer unchanged. The next frame then writes again from the current pointer.
- R6: A start pulse while idle with `free_words` below MAX_FRAME_BYTES/4 discards the frame. `drop_count` rises by one and stops at its all-ones value. `rx_wr_ok` stays low until the frame's end pulse, and the current pointer does not move.
- R7: A host write at 0xFC38 takes bits log2(RING_BYTES):2 as the new boundary in words. It is accepted only if (new - boundary) mod 2*ring words is no more than the used words (current - boundary). Otherwise it is ignored.
- R8: `ring_empty` is high exactly when the two pointers are equal including the wrap bit. `ring_full` is high exactly when the addresses match and the wrap bits differ. `free_words` equals the ring words minus the used words.
- R9: When a good end and a boundary write fall in the same cycle, both take effect. The boundary check uses the current pointer from before that cycle's commit.
- R10: A start pulse while a frame is open is ignored: the write address continues and no drop is counted. A write pulse while idle gives `rx_wr_ok` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sof | input | 1 | Frame start pulse from receive logic |
| rx_wr_en | input | 1 | One word of frame data is presented |
| rx_end_good | input | 1 | Frame ended with good status |
| rx_end_bad | input | 1 | Frame ended with bad status |
| rx_len | input | LEN_W | Frame length in bytes, valid with rx_end_good |
| rx_wr_addr | output | log2(RING_BYTES) | Byte address for the current word write |
| rx_wr_ok | output | 1 | Write enable toward the storage array |
| rx_busy | output | 1 | A frame (kept or discarded) is open |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 16 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| ring_full | output | 1 | Ring holds ring-size words |
| ring_empty | output | 1 | Ring holds no words |
| free_words | output | log2(RING_BYTES/4)+1 | Free space in words |
| drop_count | output | DROP_W | Frames discarded for lack of space |

## Verification
Two updates can land in one cycle: the hardware commit of a good frame and a software boundary write. The bench ends a frame good in the very cycle the host writes the boundary register. It does this once with a target just past the old current pointer, which must be refused even though the commit would have made room. It does it once with a target equal to the old current pointer, which must be accepted. After each case it reads both pointers back and compares them with values computed from the pre-commit state. The same arithmetic model runs through a sweep of every frame length, with mixed good and bad endings, releases at irregular intervals, filling to full and repeated drops. That sweep checks the start-time space test against the boundary value left by the previous cycle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_RECV = 2'd1,
      FS_DROP = 2'd2
   } rxr_fstate_e;

   function automatic int words_of_bytes(input int nbytes);
      return (nbytes + 3) / 4;
   endfunction

endpackage

// File: rtl/rxr_status.sv
module rxr_status #(
   parameter int RING_WORDS = 8192,
   parameter int PW         = 14
) (
   input  logic [PW-1:0] cur_i,
   input  logic [PW-1:0] bnd_i,
   output logic [PW-1:0] used_o,
   output logic [PW-1:0] free_o,
   output logic          full_o,
   output logic          empty_o
);
   localparam int AW = PW - 1;

   always_comb begin
      used_o  = cur_i - bnd_i;
      free_o  = PW'(RING_WORDS) - used_o;
      empty_o = (cur_i == bnd_i);
      full_o  = (cur_i[AW-1:0] == bnd_i[AW-1:0]) && (cur_i[AW] != bnd_i[AW]);
   end

endmodule

// File: rtl/rxr_bound_reg.sv
module rxr_bound_reg #(
   parameter int PW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req_i,
   input  logic [PW-1:0] wr_val_i,
   input  logic [PW-1:0] cur_i,
   output logic [PW-1:0] bnd_o
);
   logic [PW-1:0] bnd_q;
   logic [PW-1:0] used_now;
   logic [PW-1:0] step;
   logic          take;

   always_comb begin
      used_now = cur_i - bnd_q;
      step     = wr_val_i - bnd_q;
      take     = wr_req_i && (step <= used_now);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    bnd_q <= '0;
      else if (take) bnd_q <= wr_val_i;
   end

   assign bnd_o = bnd_q;

   assert_reject_keeps_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_i && ((wr_val_i - bnd_o) > (cur_i - bnd_o))) |=> $stable(bnd_o));

   assert_bound_follows_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_i && ((wr_val_i - bnd_o) <= (cur_i - bnd_o))) |=> (bnd_o == $past(wr_val_i)));

endmodule

// File: rtl/rxr_frame_ctrl.sv
module rxr_frame_ctrl
   import rxr_pkg::*;
#(
   parameter int PW            = 14,
   parameter int MAX_WORDS     = 384,
   parameter int MAX_BYTES     = 1536,
   parameter int LEN_W         = 16,
   parameter int DROP_W        = 16,
   parameter bit DROP_SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_i,
   input  logic              wr_en_i,
   input  logic              end_good_i,
   input  logic              end_bad_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [PW-1:0]     free_i,
   output logic [PW-1:0]     cur_o,
   output logic [PW-2:0]     wr_word_o,
   output logic              wr_ok_o,
   output logic              busy_o,
   output logic [DROP_W-1:0] drop_o
);
   localparam int AW    = PW - 1;
   localparam int CNT_W = $clog2(MAX_WORDS + 1);

   rxr_fstate_e       state_q;
   logic [PW-1:0]     cur_q;
   logic [PW-1:0]     wr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DROP_W-1:0] drop_q;
   logic [DROP_W-1:0] drop_nx;

   logic              room;
   logic              end_any;
   logic              len_ok;
   logic [LEN_W:0]    len_rnd;
   logic [PW-1:0]     commit_w;

   always_comb begin
      room     = (free_i >= PW'(MAX_WORDS));
      end_any  = end_good_i || end_bad_i;
      len_ok   = ({1'b0, len_i} <= (LEN_W+1)'(MAX_BYTES));
      len_rnd  = ({1'b0, len_i} + (LEN_W+1)'(3)) >> 2;
      commit_w = PW'(len_rnd);
      wr_ok_o  = (state_q == FS_RECV) && wr_en_i && !end_any
                 && (cnt_q < CNT_W'(MAX_WORDS));
   end

   generate
      if (DROP_SATURATE) begin : g_drop_sat
         assign drop_nx = (&drop_q) ? drop_q : drop_q + 1'b1;
      end else begin : g_drop_wrap
         assign drop_nx = drop_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         cur_q   <= '0;
         wr_q    <= '0;
         cnt_q   <= '0;
         drop_q  <= '0;
      end else begin
         unique case (state_q)
            FS_IDLE: begin
               if (sof_i) begin
                  if (room) begin
                     state_q <= FS_RECV;
                     wr_q    <= cur_q;
                     cnt_q   <= '0;
                  end else begin
                     state_q <= FS_DROP;
                     drop_q  <= drop_nx;
                  end
               end
            end
            FS_RECV: begin
               if (end_any) begin
                  state_q <= FS_IDLE;
                  if (end_good_i && len_ok) begin
                     cur_q <= cur_q + commit_w;
                     wr_q  <= cur_q + commit_w;
                  end else begin
                     wr_q  <= cur_q;
                  end
               end else if (wr_ok_o) begin
                  wr_q  <= wr_q + 1'b1;
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            FS_DROP: begin
               if (end_any) state_q <= FS_IDLE;
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign cur_o     = cur_q;
   assign wr_word_o = wr_q[AW-1:0];
   assign busy_o    = (state_q != FS_IDLE);
   assign drop_o    = drop_q;

   assert_cur_moves_on_good_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(state_q == FS_RECV && end_good_i && len_ok) |=> $stable(cur_o));

   assert_window_within_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok_o |-> ((wr_q - cur_q) < PW'(MAX_WORDS)));

   assert_drop_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && sof_i && !room && !(&drop_o)) |=> (drop_o == $past(drop_o) + 1'b1));

   assert_silent_while_dropping_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_DROP) |-> !wr_ok_o);

   assert_sof_ignored_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !end_any) |=> ($stable(drop_o) && busy_o));

endmodule

// File: rtl/rxr_ptr_mgr.sv
module rxr_ptr_mgr #(
   parameter int              RING_BYTES      = 32768,
   parameter int              MAX_FRAME_BYTES = 1536,
   parameter int              LEN_W           = 16,
   parameter int              DROP_W          = 16,
   parameter bit              DROP_SATURATE   = 1'b1,
   parameter logic [15:0]     CUR_OFFSET      = 16'hFC34,
   parameter logic [15:0]     BND_OFFSET      = 16'hFC38
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rx_sof,
   input  logic                            rx_wr_en,
   input  logic                            rx_end_good,
   input  logic                            rx_end_bad,
   input  logic [LEN_W-1:0]                rx_len,
   output logic [$clog2(RING_BYTES)-1:0]   rx_wr_addr,
   output logic                            rx_wr_ok,
   output logic                            rx_busy,
   input  logic                            host_we,
   input  logic [15:0]                     host_addr,
   input  logic [31:0]                     host_wdata,
   output logic [31:0]                     host_rdata,
   output logic                            ring_full,
   output logic                            ring_empty,
   output logic [$clog2(RING_BYTES/4):0]   free_words,
   output logic [DROP_W-1:0]               drop_count
);
   localparam int RING_WORDS = RING_BYTES / 4;
   localparam int AW         = $clog2(RING_WORDS);
   localparam int PW         = AW + 1;
   localparam int MAX_WORDS  = rxr_pkg::words_of_bytes(MAX_FRAME_BYTES);

   generate
      if ((1 << $clog2(RING_BYTES)) != RING_BYTES || RING_BYTES < 16) begin : g_bad_ring
         $error("RING_BYTES must be a power of two of at least 16");
      end
      if ((MAX_FRAME_BYTES % 4) != 0 || MAX_FRAME_BYTES > RING_BYTES || MAX_FRAME_BYTES < 4) begin : g_bad_max
         $error("MAX_FRAME_BYTES must be a word multiple within the ring");
      end
      if ((1 << LEN_W) <= MAX_FRAME_BYTES) begin : g_bad_len
         $error("LEN_W too narrow for MAX_FRAME_BYTES");
      end
      if (PW + 2 > 32) begin : g_bad_bus
         $error("pointer does not fit the host data bus");
      end
   endgenerate

   logic [PW-1:0] cur_w;
   logic [PW-1:0] bnd_w;
   logic [PW-1:0] used_w;
   logic [PW-1:0] free_w;
   logic [AW-1:0] wr_word;
   logic          bnd_wr;
   logic          unused_wdata;

   assign bnd_wr       = host_we && (host_addr == BND_OFFSET);
   assign unused_wdata = ^{host_wdata[31:PW+2], host_wdata[1:0]};

   rxr_frame_ctrl #(
      .PW            (PW),
      .MAX_WORDS     (MAX_WORDS),
      .MAX_BYTES     (MAX_FRAME_BYTES),
      .LEN_W         (LEN_W),
      .DROP_W        (DROP_W),
      .DROP_SATURATE (DROP_SATURATE)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof_i      (rx_sof),
      .wr_en_i    (rx_wr_en),
      .end_good_i (rx_end_good),
      .end_bad_i  (rx_end_bad),
      .len_i      (rx_len),
      .free_i     (free_w),
      .cur_o      (cur_w),
      .wr_word_o  (wr_word),
      .wr_ok_o    (rx_wr_ok),
      .busy_o     (rx_busy),
      .drop_o     (drop_count)
   );

   rxr_bound_reg #(
      .PW (PW)
   ) u_bound (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req_i (bnd_wr),
      .wr_val_i (host_wdata[PW+1:2]),
      .cur_i    (cur_w),
      .bnd_o    (bnd_w)
   );

   rxr_status #(
      .RING_WORDS (RING_WORDS),
      .PW         (PW)
   ) u_status (
      .cur_i   (cur_w),
      .bnd_i   (bnd_w),
      .used_o  (used_w),
      .free_o  (free_w),
      .full_o  (ring_full),
      .empty_o (ring_empty)
   );

   always_comb begin
      host_rdata = '0;
      if (host_addr == CUR_OFFSET)      host_rdata[PW+1:0] = {cur_w, 2'b00};
      else if (host_addr == BND_OFFSET) host_rdata[PW+1:0] = {bnd_w, 2'b00};
   end

   assign rx_wr_addr = {wr_word, 2'b00};
   assign free_words = free_w;

   assert_full_empty_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ring_full && ring_empty));

   assert_full_means_no_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ring_full |-> (free_words == '0));

   assert_empty_means_all_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ring_empty |-> (free_words == PW'(RING_WORDS)));

   assert_used_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      used_w <= PW'(RING_WORDS));

   assert_cur_reg_read_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == CUR_OFFSET && !rx_end_good) |=> $stable(cur_w));

endmodule

// File: tb/rxr_ptr_mgr_test.sv
module rxr_ptr_mgr_test;
   localparam int CLK_PERIOD = 10;
   localparam int RB  = 256;
   localparam int RW  = RB / 4;
   localparam int MW  = 8;
   localparam int MB  = 32;
   localparam int PM  = 2 * RW;
   localparam int DMAX = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_sof = 1'b0, rx_wr_en = 1'b0, rx_end_good = 1'b0, rx_end_bad = 1'b0;
   logic [7:0]  rx_len = '0;
   logic [7:0]  rx_wr_addr;
   logic        rx_wr_ok, rx_busy;
   logic        host_we = 1'b0;
   logic [15:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        ring_full, ring_empty;
   logic [6:0]  free_words;
   logic [2:0]  drop_count;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;
   int m_cur = 0, m_bnd = 0, m_drop = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxr_ptr_mgr #(
      .RING_BYTES(RB), .MAX_FRAME_BYTES(MB), .LEN_W(8), .DROP_W(3)
   ) uut (
      .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_wr_en(rx_wr_en),
      .rx_end_good(rx_end_good), .rx_end_bad(rx_end_bad), .rx_len(rx_len),
      .rx_wr_addr(rx_wr_addr), .rx_wr_ok(rx_wr_ok), .rx_busy(rx_busy),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .ring_full(ring_full), .ring_empty(ring_empty),
      .free_words(free_words), .drop_count(drop_count)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int used_m();
      return (m_cur - m_bnd + PM) % PM;
   endfunction

   function automatic void model_bnd(input int val);
      int nw;
      nw = (val >> 2) % PM;
      if (((nw - m_bnd + PM) % PM) <= used_m()) m_bnd = nw;
   endfunction

   task automatic check_status();
      chk("R8 empty", int'(ring_empty), int'(m_cur == m_bnd));
      chk("R8 full", int'(ring_full), int'(used_m() == RW));
      chk("R8 free", int'(free_words), RW - used_m());
      chk("R6 drop_count", int'(drop_count), m_drop);
      host_addr = 16'hFC34; #1;
      chk("R2 cur read", int'(host_rdata), m_cur * 4);
      host_addr = 16'hFC38; #1;
      chk("R2 bnd read", int'(host_rdata), m_bnd * 4);
      host_addr = 16'h0000;
   endtask

   task automatic bnd_write(input int val);
      host_we = 1'b1; host_addr = 16'hFC38; host_wdata = val;
      tick();
      host_we = 1'b0; host_wdata = '0;
      model_bnd(val);
      check_status();
   endtask

   // sw < 0: no boundary write during the end cycle
   task automatic frame(input int nwr, input int len, input bit good, input int sw);
      bit acc;
      acc = (RW - used_m()) >= MW;
      rx_sof = 1'b1;
      tick();
      rx_sof = 1'b0;
      chk("R10 busy after start", int'(rx_busy), 1);
      if (!acc && m_drop < DMAX) m_drop++;
      for (int i = 0; i < nwr; i++) begin
         rx_wr_en = 1'b1; #1;
         chk(acc ? "R3 wr_ok" : "R6 wr_ok while dropped", int'(rx_wr_ok), int'(acc && i < MW));
         if (acc && i < MW) chk("R3 wr_addr", int'(rx_wr_addr), ((m_cur + i) % RW) * 4);
         tick();
         rx_wr_en = 1'b0;
      end
      if (good) begin rx_end_good = 1'b1; rx_len = 8'(len); end
      else rx_end_bad = 1'b1;
      if (sw >= 0) begin host_we = 1'b1; host_addr = 16'hFC38; host_wdata = sw; end
      tick();
      rx_end_good = 1'b0; rx_end_bad = 1'b0; host_we = 1'b0; host_wdata = '0;
      if (sw >= 0) model_bnd(sw);
      if (acc && good && len <= MB) m_cur = (m_cur + (len + 3) / 4) % PM;
      chk("R4/R5 busy cleared", int'(rx_busy), 0);
      check_status();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", int'(rx_busy), 0);
      chk("R1 empty", int'(ring_empty), 1);
      chk("R1 free", int'(free_words), RW);
      check_status();
      host_addr = 16'hFC30; #1;
      chk("R2 other offset", int'(host_rdata), 0);
      // R10 idle write
      rx_wr_en = 1'b1; #1;
      chk("R10 idle write", int'(rx_wr_ok), 0);
      tick(); rx_wr_en = 1'b0;

      // sweep of all lengths, mixed endings and irregular releases
      for (int len = 0; len <= 40; len++) begin
         int nw;
         nw = (len + 3) / 4;
         if (nw > 10) nw = 10;
         frame(nw, len, (len % 5) != 1, -1);
         if ((len % 4) == 3) bnd_write(m_cur * 4);
         else if ((len % 7) == 5) bnd_write(((m_bnd + 2) % PM) * 4);
      end

      // R7 rejected boundary past current, then accepted partial advance
      frame(3, 12, 1'b1, -1);
      bnd_write(((m_cur + 1) % PM) * 4);
      bnd_write(((m_bnd + 1) % PM) * 4);
      // R2 write to current offset ignored
      host_we = 1'b1; host_addr = 16'hFC34; host_wdata = 32'h40;
      tick(); host_we = 1'b0;
      check_status();

      // R5 overlong good length rolls back; R3 writes beyond window
      bnd_write(m_cur * 4);
      frame(10, 33, 1'b1, -1);
      frame(10, 32, 1'b1, -1);

      // R9 same-cycle commit and boundary write
      bnd_write(m_cur * 4);
      frame(2, 8, 1'b1, ((m_cur + 1) % PM) * 4);
      frame(2, 8, 1'b1, m_cur * 4);

      // fill to full, then R6 drops to saturation
      bnd_write(m_cur * 4);
      for (int k = 0; k < 8; k++) frame(8, 32, 1'b1, -1);
      chk("R8 full reached", int'(ring_full), 1);
      for (int k = 0; k < 9; k++) frame(2, 8, 1'b1, -1);
      chk("R6 saturated", int'(drop_count), DMAX);

      // R10 second start while open is ignored
      bnd_write(m_cur * 4);
      rx_sof = 1'b1; tick(); rx_sof = 1'b0;
      rx_wr_en = 1'b1; tick(); tick(); rx_wr_en = 1'b0;
      rx_sof = 1'b1; tick(); rx_sof = 1'b0;
      chk("R10 still busy", int'(rx_busy), 1);
      rx_wr_en = 1'b1; #1;
      chk("R10 address continues", int'(rx_wr_addr), ((m_cur + 2) % RW) * 4);
      tick(); rx_wr_en = 1'b0;
      rx_end_good = 1'b1; rx_len = 8'd12; tick(); rx_end_good = 1'b0;
      m_cur = (m_cur + 3) % PM;
      check_status();

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule